// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed running sum, exposed as a high word and a low word, and adds one signed product to it each time an operation is issued. Two operation kinds exist. The long kind multiplies two full 32-bit signed operands. The word kind multiplies only the signed low 16-bit halves of the operands. A saturation-mode input, normally wired from a processor status bit, changes how each kind writes its sum back. The two kinds follow different clamping rules.

A controller issues an operation by raising `op_valid` for one cycle, with the operands, the kind select and the saturation mode. The updated accumulator appears one cycle later, together with a one-cycle `done` flag. A `clr` strobe empties the accumulator in a single cycle. A small state machine tracks issue and completion. It has two states. `ST_IDLE` means no result was produced in the previous cycle. `ST_DONE` means a result was written in the previous cycle. The transition `T_ACCEPT` (op_valid high, clr low) enters or stays in `ST_DONE`. The transition `T_RETIRE` (no accepted operation) returns from `ST_DONE` to `ST_IDLE`. The transition `T_CLEAR` (clr high) goes to `ST_IDLE` from either state.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset, `acc_hi` and `acc_lo` are zero and `done` is low.
- R2: A long operation (`op_sel` = 0) sign-extends both 32-bit operands, forms their 64-bit signed product and adds it to the 64-bit value {acc_hi, acc_lo}.
- R3: A word operation (`op_sel` = 1) uses only bits 15:0 of each operand as signed 16-bit values. Bits 31:16 of the operands have no effect. The signed product is added to the 64-bit accumulator.
- R4: With `sat_en` low, both kinds store the full 64-bit sum, wrapping modulo 2^64, with the upper 32 bits in `acc_hi` and the lower 32 bits in `acc_lo`.
- R5: With `sat_en` high, a long operation whose 64-bit sum is negative stores the sum with bits 31:16 of `acc_hi` forced to one. `acc_lo` and the other bits are taken from the sum.
- R6: With `sat_en` high, a long operation whose 64-bit sum is zero or positive stores `acc_hi` masked to its bits 14:0. `acc_lo` is the low half of the sum.
- R7: With `sat_en` high, a word operation whose sum is below -2^31 stores `acc_hi` = 1 and `acc_lo` = 0x80000000.
- R8: With `sat_en` high, a word operation whose sum is above 2^31-1 stores `acc_hi` = 1 and `acc_lo` = 0x7FFFFFFF. A sum in the range [-2^31, 2^31-1] is stored unchanged.
- R9: `clr` zeroes both words at the next clock edge. If `clr` and `op_valid` are high in the same cycle, the clear wins: the accumulator becomes zero and `done` stays low in the next cycle.
- R10: `done` is high exactly in the cycle after an accepted operation, and the new accumulator value is visible in that cycle. Without an accepted operation or a clear, the accumulator holds its value and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe for one operation |
| op_sel | input | 1 | 0 = long 32x32, 1 = word 16x16 |
| sat_en | input | 1 | Saturation mode for this operation |
| clr | input | 1 | Zero the accumulator |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| acc_hi | output | 32 | Upper accumulator word |
| acc_lo | output | 32 | Lower accumulator word |
| done | output | 1 | Result written in the previous cycle |

## Verification
Two functions can fall in the same cycle: the clear strobe and an issued operation. Both write the accumulator and both drive the state machine. The bench first loads a non-zero accumulator, then raises `clr` and `op_valid` together. In the following cycle it expects a zero accumulator and a low `done`, and a later operation must start from zero. The operand sweeps also issue operations back to back, so that `T_ACCEPT` repeats from `ST_DONE`, and mix them with idle gaps that exercise `T_RETIRE`.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic {
        OP_LONG = 1'b0,
        OP_WORD = 1'b1
    } mac_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } mac_state_e;

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  mac_op_e                  op,
    input  logic [WORD_W-1:0]        a,
    input  logic [WORD_W-1:0]        b,
    output logic [2*WORD_W-1:0]      prod
);
    localparam int ACC_W = 2 * WORD_W;

    logic signed [ACC_W-1:0] ext_a;
    logic signed [ACC_W-1:0] ext_b;

    always_comb begin
        unique case (op)
            OP_LONG: begin
                ext_a = {{WORD_W{a[WORD_W-1]}}, a};
                ext_b = {{WORD_W{b[WORD_W-1]}}, b};
            end
            OP_WORD: begin
                ext_a = {{(ACC_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
                ext_b = {{(ACC_W-HALF_W){b[HALF_W-1]}}, b[HALF_W-1:0]};
            end
            default: begin
                ext_a = '0;
                ext_b = '0;
            end
        endcase
        prod = ext_a * ext_b;
    end

endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
    import mac_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  mac_op_e              op,
    input  logic                 sat_en,
    input  logic [2*WORD_W-1:0]  sum,
    output logic [WORD_W-1:0]    hi,
    output logic [WORD_W-1:0]    lo
);
    localparam int ACC_W = 2 * WORD_W;
    localparam logic [WORD_W-1:0] HI_NEG_SET  = {{HALF_W{1'b1}}, {(WORD_W-HALF_W){1'b0}}};
    localparam logic [WORD_W-1:0] HI_POS_KEEP = {{(WORD_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [ACC_W-1:0]  WORD_MIN    = {{(ACC_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
    localparam logic [ACC_W-1:0]  WORD_MAX    = {{(ACC_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] MARK_HI     = WORD_W'(1);
    localparam logic [WORD_W-1:0] LO_NEG_LIM  = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] LO_POS_LIM  = {1'b0, {(WORD_W-1){1'b1}}};

    logic [WORD_W-1:0] raw_hi;
    logic [WORD_W-1:0] raw_lo;
    logic              below;
    logic              above;

    assign raw_hi = sum[ACC_W-1:WORD_W];
    assign raw_lo = sum[WORD_W-1:0];
    assign below  = $signed(sum) < $signed(WORD_MIN);
    assign above  = $signed(sum) > $signed(WORD_MAX);

    always_comb begin
        hi = raw_hi;
        lo = raw_lo;
        if (sat_en) begin
            unique case (op)
                OP_LONG: begin
                    if (sum[ACC_W-1]) hi = raw_hi | HI_NEG_SET;
                    else              hi = raw_hi & HI_POS_KEEP;
                end
                OP_WORD: begin
                    if (below) begin
                        hi = MARK_HI;
                        lo = LO_NEG_LIM;
                    end else if (above) begin
                        hi = MARK_HI;
                        lo = LO_POS_LIM;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_sel,
    input  logic              sat_en,
    input  logic              clr,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output logic [WORD_W-1:0] acc_hi,
    output logic [WORD_W-1:0] acc_lo,
    output logic              done
);
    localparam int ACC_W = 2 * WORD_W;

    mac_state_e        state_q, state_d;
    mac_op_e           op;
    logic              accept;
    logic [ACC_W-1:0]  prod;
    logic [ACC_W-1:0]  sum;
    logic [WORD_W-1:0] nxt_hi;
    logic [WORD_W-1:0] nxt_lo;

    assign op     = mac_op_e'(op_sel);
    assign accept = op_valid && !clr;
    assign sum    = {acc_hi, acc_lo} + prod;

    mac_product #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_prod (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .prod (prod)
    );

    mac_saturate #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_sat (
        .op     (op),
        .sat_en (sat_en),
        .sum    (sum),
        .hi     (nxt_hi),
        .lo     (nxt_lo)
    );

    // Next-state logic: T_CLEAR, T_ACCEPT, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_DONE;
            ST_DONE: if (!accept) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (clr) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process: accumulator and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (clr) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (op_valid) begin
            acc_hi <= nxt_hi;
            acc_lo <= nxt_lo;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_DONE: done = 1'b1;
            default: done = 1'b0;
        endcase
    end

    // R9: a clear empties the accumulator and suppresses done
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_hi == '0) && (acc_lo == '0) && !done);

    // R10: done follows an accepted operation
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr) |=> done);

    // R10: no done without an accepted operation
    p_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && !clr) |=> !done);

    // R10: accumulator holds when nothing is issued
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !clr) |=> $stable(acc_hi) && $stable(acc_lo));

    // R5, R6: a saturated long result keeps acc_hi within the 48-bit window
    p_long_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && sat_en && !op_sel) |=>
            ((&acc_hi[WORD_W-1:WORD_W-HALF_W]) || (acc_hi[WORD_W-1:HALF_W-1] == '0)));

    // R7, R8: a saturated word result is a 32-bit value or carries the marker
    p_word_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && sat_en && op_sel) |=>
            ((acc_hi == WORD_W'(1)) || (acc_hi == {WORD_W{acc_lo[WORD_W-1]}})));

endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic        sat_en = 1'b0;
    logic        clr = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;
    logic [63:0] m_acc = '0;
    int cycles = 0;

    always #5 clk = ~clk;

    mac_sat_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .sat_en(sat_en), .clr(clr), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string model(input logic op, input logic [31:0] a,
                                    input logic [31:0] b, input logic sat);
        longint pa, pb, sum;
        logic [31:0] hi;
        string tag;
        if (op) begin
            pa = longint'($signed(a[15:0]));
            pb = longint'($signed(b[15:0]));
            tag = "R3";
        end else begin
            pa = longint'($signed(a));
            pb = longint'($signed(b));
            tag = "R2";
        end
        sum = longint'(m_acc) + pa * pb;
        if (!sat) begin
            m_acc = sum;
            return {tag, "/R4"};
        end
        if (!op) begin
            hi = sum[63:32];
            if (sum < 0) begin hi = hi | 32'hFFFF0000; tag = "R5"; end
            else         begin hi = hi & 32'h00007FFF; tag = "R6"; end
            m_acc = {hi, sum[31:0]};
        end else if (sum < -64'sd2147483648) begin
            m_acc = {32'd1, 32'h80000000}; tag = "R7";
        end else if (sum > 64'sd2147483647) begin
            m_acc = {32'd1, 32'h7FFFFFFF}; tag = "R8";
        end else begin
            m_acc = sum; tag = "R8";
        end
        return tag;
    endfunction

    task automatic issue(input logic op, input logic [31:0] a, input logic [31:0] b,
                         input logic sat);
        string tag;
        tag = model(op, a, b, sat);
        op_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; sat_en = sat;
        @(negedge clk);
        op_valid = 1'b0;
        check("R10 done", {63'd0, done}, 64'd1);
        check(tag, {acc_hi, acc_lo}, m_acc);
    endtask

    task automatic clear_acc();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_acc = '0;
        check("R9 clear", {acc_hi, acc_lo}, 64'd0);
    endtask

    initial begin
        logic [31:0] vals [8];
        vals = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF,
                 32'h80000000, 32'h00007FFF, 32'hABCD8000, 32'h12345678};
        repeat (3) @(negedge clk);
        check("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
        check("R1 reset done", {63'd0, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int s = 0; s < 2; s++) begin
            for (int o = 0; o < 2; o++) begin
                clear_acc();
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        issue(o[0], vals[i], vals[j], s[0]);
                    end
                    @(negedge clk);
                    check("R10 retire", {63'd0, done}, 64'd0);
                end
            end
        end

        // R3: upper operand bits ignored
        clear_acc();
        issue(1'b1, 32'hFFFF0003, 32'h12340005, 1'b0);
        check("R3 upper ignored", {acc_hi, acc_lo}, 64'd15);

        // R7: drive below -2^31
        clear_acc();
        for (int k = 0; k < 3; k++) issue(1'b1, 32'h00008000, 32'h00007FFF, 1'b1);
        check("R7 neg clamp", {acc_hi, acc_lo}, {32'd1, 32'h80000000});

        // R8: drive above 2^31-1
        clear_acc();
        for (int k = 0; k < 3; k++) issue(1'b1, 32'h00008000, 32'h00008000, 1'b1);
        check("R8 pos clamp", {acc_hi, acc_lo}, {32'd1, 32'h7FFFFFFF});

        // R10: idle hold
        repeat (3) @(negedge clk);
        check("R10 hold", {acc_hi, acc_lo}, {32'd1, 32'h7FFFFFFF});
        check("R10 idle done", {63'd0, done}, 64'd0);

        // R9: clear and valid in the same cycle
        clr = 1'b1; op_valid = 1'b1; op_sel = 1'b0;
        opnd_a = 32'h100; opnd_b = 32'h100; sat_en = 1'b0;
        @(negedge clk);
        clr = 1'b0; op_valid = 1'b0;
        m_acc = '0;
        check("R9 clear wins acc", {acc_hi, acc_lo}, 64'd0);
        check("R9 clear wins done", {63'd0, done}, 64'd0);
        issue(1'b0, 32'h5, 32'hFFFFFFFD, 1'b0);
        check("R9 restart from zero", {acc_hi, acc_lo}, 64'hFFFFFFFFFFFFFFF1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule